// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block takes a system out of a clock-stopped standby state in two phases. A single-cycle entry request puts it into standby: the oscillator enable, every clock gate and the clock-output enable drop, and the settling-time select is captured. In standby it watches one non-maskable interrupt pin, eight maskable interrupt pins and an active-low power-on reset pin. All pins pass through two-flop synchronizers on the always-running detection clock.

A qualifying edge starts the oscillator and opens the clock gate of the settling counter only. The system clock stays off. The counter is an 8-bit count behind a prescaler chosen by the captured 3-bit select. When the count wraps from 255, the system clock is released and a one-cycle exception request names the source of the wake. A maskable source whose priority is below the CPU mask level is dropped, and standby continues.

A low reset pin overrides all of this at once: clocks run, a reset hold output stays high while the pin is low, and a reset exception pulses when the pin goes high again. Status outputs give the sequencer state and a wake-cause code.

Top module: `stby_wake_seq`

## Requirements
- R1: After block reset the state output is 0 (RUN), sys_clk_en, osc_en and clkout_en are 1, wdt_clk_en, por_hold and all exception outputs are 0, and wake_cause is 0.
- R2: A stby_req pulse in RUN (no reset hold) gives state 1 (STANDBY) one cycle later. In that cycle osc_en, sys_clk_en, wdt_clk_en and clkout_en are 0 and wake_cause is 0.
- R3: With nmi_rise_sel = 1 a rising NMI edge wakes the block; with 0 a falling edge does. The other edge is ignored and the state stays STANDBY.
- R4: IRQ n uses the field irq_sense[2n+1:2n]: 00 never wakes, 01 wakes on falling, 10 on rising, 11 on either edge. An edge the field does not select is ignored.
- R5: A wake moves the state to 2 (SETTLING) with osc_en, clkout_en and wdt_clk_en at 1 and sys_clk_en at 0.
- R6: SETTLING lasts exactly 256 x D cycles. D is 1, 4, 16, 32, 64, 256, 1024 or 4096 for cks values 0 to 7. cks is sampled at standby entry, so changes made during standby have no effect.
- R7: At the end of settling the state returns to RUN, sys_clk_en rises and wdt_clk_en falls. In the same cycle either exc_nmi or exc_irq (with exc_irq_num) pulses for one cycle.
- R8: IRQ n wakes only if irq_prio[4n+3:4n] >= cpu_mask. A lower priority leaves the block in STANDBY with wake_cause 0.
- R9: NMI wins over an IRQ that qualifies in the same cycle. Among IRQs that qualify together, the lowest index wins.
- R10: wake_cause is 1 for NMI, 2 for reset and 8+n for IRQ n. It holds until the next standby entry.
- R11: While the synchronized por_n is low, in any state: state is RUN, sys_clk_en, osc_en and clkout_en are 1, wdt_clk_en is 0, por_hold is 1 and wake_cause is 2. stby_req is ignored.
- R12: When por_n returns high, por_hold clears and exc_reset pulses for one cycle.
- R13: Pin edges in RUN have no effect: no exception, and the state and wake_cause do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running detection and oscillator-count clock |
| rst | input | 1 | Synchronous active-high block reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| irq_pin | input | 8 | Maskable interrupt pins |
| por_n | input | 1 | Active-low power-on reset pin |
| nmi_rise_sel | input | 1 | NMI wake edge: 1 rising, 0 falling |
| irq_sense | input | 16 | Two-bit wake-edge field per IRQ |
| irq_prio | input | 32 | Four-bit priority per IRQ |
| cpu_mask | input | 4 | CPU interrupt mask level |
| cks | input | 3 | Settling prescaler select |
| stby_req | input | 1 | Single-cycle standby entry request |
| osc_en | output | 1 | Oscillator enable |
| wdt_clk_en | output | 1 | Clock gate to the settling counter |
| sys_clk_en | output | 1 | Clock gate to the rest of the system |
| clkout_en | output | 1 | Clock output pin enable |
| exc_nmi | output | 1 | NMI exception request pulse |
| exc_irq | output | 1 | IRQ exception request pulse |
| exc_irq_num | output | 3 | IRQ index for exc_irq |
| exc_reset | output | 1 | Reset exception request pulse |
| por_hold | output | 1 | Power-on reset state active |
| state | output | 2 | 0 RUN, 1 STANDBY, 2 SETTLING |
| wake_cause | output | 4 | Wake source code |

## Verification
NMI wakes are tried with both edge selects. The opposite edge arrives first, so a swapped polarity shows up as an early wake. The IRQ pins are driven with fields set to none, falling-only, rising-only and both edges, so a sense bit that is misread wakes on the wrong edge. A priority below the mask, and one equal to it, pin down the direction of the compare. Two sources that qualify in the same cycle (two IRQs, or NMI with an IRQ) check the precedence order. Settling is timed at three prescaler values, with cks changed during standby to prove it was captured at entry. Reset is applied during settling and during standby, and a pin is toggled while running.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STBY   = 2'd1,
    ST_SETTLE = 2'd2
  } wk_state_e;

  localparam logic [3:0] CAUSE_NONE  = 4'd0;
  localparam logic [3:0] CAUSE_NMI   = 4'd1;
  localparam logic [3:0] CAUSE_RESET = 4'd2;
  localparam logic [3:0] CAUSE_IRQ   = 4'd8;

  // prescaler select -> log2 of oscillator cycles per counter step
  function automatic logic [3:0] div_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    div_shift = 4'd0;
      3'd1:    div_shift = 4'd2;
      3'd2:    div_shift = 4'd4;
      3'd3:    div_shift = 4'd5;
      3'd4:    div_shift = 4'd6;
      3'd5:    div_shift = 4'd8;
      3'd6:    div_shift = 4'd10;
      default: div_shift = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/wk_pin_sync.sv
module wk_pin_sync #(
  parameter int          N       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pin
      logic s1, s2, prev;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1   <= RST_VAL;
          s2   <= RST_VAL;
          prev <= RST_VAL;
        end else begin
          s1   <= pin[g];
          s2   <= s1;
          prev <= s2;
        end
      end
      assign level[g] = s2;
      assign rise[g]  = s2 & ~prev;
      assign fall[g]  = ~s2 & prev;
    end
  endgenerate
endmodule

// File: rtl/wk_src_arb.sv
module wk_src_arb #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic                    nmi_rise,
  input  logic                    nmi_fall,
  input  logic                    nmi_rise_sel,
  input  logic [N_IRQ-1:0]        irq_rise,
  input  logic [N_IRQ-1:0]        irq_fall,
  input  logic [2*N_IRQ-1:0]      irq_sense,
  input  logic [PRIO_W*N_IRQ-1:0] irq_prio,
  input  logic [PRIO_W-1:0]       cpu_mask,
  output logic                    hit,
  output logic                    is_nmi,
  output logic [IDX_W-1:0]        irq_idx
);
  logic             nmi_ok;
  logic [N_IRQ-1:0] irq_ok;

  assign nmi_ok = nmi_rise_sel ? nmi_rise : nmi_fall;

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_q
      logic edge_sel, prio_ok;
      assign edge_sel = (irq_sense[2*g+1] & irq_rise[g]) | (irq_sense[2*g] & irq_fall[g]);
      assign prio_ok  = irq_prio[PRIO_W*g +: PRIO_W] >= cpu_mask;
      assign irq_ok[g] = edge_sel & prio_ok;
    end
  endgenerate

  // lowest index wins: scan downward, last hit kept
  always_comb begin
    irq_idx = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (irq_ok[i]) irq_idx = IDX_W'(i);
    end
  end

  assign is_nmi = nmi_ok;
  assign hit    = nmi_ok | (|irq_ok);
endmodule

// File: rtl/wk_settle_timer.sv
module wk_settle_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       run,
  input  logic [2:0] cks,
  output logic       ovf
);
  import wk_pkg::*;

  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  always_comb pre_lim = ~({PRE_W{1'b1}} << div_shift(cks));
  assign tick = run && (pre_cnt == pre_lim);
  assign ovf  = tick && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (run) begin
      if (tick) begin
        pre_cnt <= '0;
        cnt     <= cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  // R6: counter advances by at most one step per cycle while running
  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    (run && !clear) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/stby_wake_seq.sv
module stby_wake_seq #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 4,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 12,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    nmi_pin,
  input  logic [N_IRQ-1:0]        irq_pin,
  input  logic                    por_n,
  input  logic                    nmi_rise_sel,
  input  logic [2*N_IRQ-1:0]      irq_sense,
  input  logic [PRIO_W*N_IRQ-1:0] irq_prio,
  input  logic [PRIO_W-1:0]       cpu_mask,
  input  logic [2:0]              cks,
  input  logic                    stby_req,
  output logic                    osc_en,
  output logic                    wdt_clk_en,
  output logic                    sys_clk_en,
  output logic                    clkout_en,
  output logic                    exc_nmi,
  output logic                    exc_irq,
  output logic [IDX_W-1:0]        exc_irq_num,
  output logic                    exc_reset,
  output logic                    por_hold,
  output logic [1:0]              state,
  output logic [3:0]              wake_cause
);
  import wk_pkg::*;

  wk_state_e        st;
  logic             nmi_lvl, nmi_r, nmi_f;
  logic [N_IRQ-1:0] irq_lvl, irq_r, irq_f;
  logic             por_s, por_r, por_f;
  logic             arb_hit, arb_nmi;
  logic [IDX_W-1:0] arb_idx;
  logic             src_nmi_q;
  logic [IDX_W-1:0] src_idx_q;
  logic [2:0]       cks_q;
  logic             ovf;

  wk_pin_sync #(.N(1), .RST_VAL(1'b0)) u_nmi_sync (
    .clk(clk), .rst(rst), .pin(nmi_pin), .level(nmi_lvl), .rise(nmi_r), .fall(nmi_f));

  wk_pin_sync #(.N(N_IRQ), .RST_VAL(1'b0)) u_irq_sync (
    .clk(clk), .rst(rst), .pin(irq_pin), .level(irq_lvl), .rise(irq_r), .fall(irq_f));

  wk_pin_sync #(.N(1), .RST_VAL(1'b1)) u_por_sync (
    .clk(clk), .rst(rst), .pin(por_n), .level(por_s), .rise(por_r), .fall(por_f));

  wk_src_arb #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .nmi_rise(nmi_r), .nmi_fall(nmi_f), .nmi_rise_sel(nmi_rise_sel),
    .irq_rise(irq_r), .irq_fall(irq_f), .irq_sense(irq_sense),
    .irq_prio(irq_prio), .cpu_mask(cpu_mask),
    .hit(arb_hit), .is_nmi(arb_nmi), .irq_idx(arb_idx));

  wk_settle_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timer (
    .clk(clk), .rst(rst), .clear(st != ST_SETTLE), .run(st == ST_SETTLE),
    .cks(cks_q), .ovf(ovf));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_RUN;
      osc_en      <= 1'b1;
      sys_clk_en  <= 1'b1;
      clkout_en   <= 1'b1;
      wdt_clk_en  <= 1'b0;
      exc_nmi     <= 1'b0;
      exc_irq     <= 1'b0;
      exc_irq_num <= '0;
      exc_reset   <= 1'b0;
      por_hold    <= 1'b0;
      wake_cause  <= CAUSE_NONE;
      src_nmi_q   <= 1'b0;
      src_idx_q   <= '0;
      cks_q       <= '0;
    end else begin
      exc_nmi   <= 1'b0;
      exc_irq   <= 1'b0;
      exc_reset <= 1'b0;
      if (!por_s) begin
        st         <= ST_RUN;
        osc_en     <= 1'b1;
        sys_clk_en <= 1'b1;
        clkout_en  <= 1'b1;
        wdt_clk_en <= 1'b0;
        por_hold   <= 1'b1;
        wake_cause <= CAUSE_RESET;
      end else if (por_hold) begin
        por_hold  <= 1'b0;
        exc_reset <= 1'b1;
      end else begin
        unique case (st)
          ST_RUN: begin
            if (stby_req) begin
              st         <= ST_STBY;
              osc_en     <= 1'b0;
              sys_clk_en <= 1'b0;
              clkout_en  <= 1'b0;
              wdt_clk_en <= 1'b0;
              wake_cause <= CAUSE_NONE;
              cks_q      <= cks;
            end
          end
          ST_STBY: begin
            if (arb_hit) begin
              st         <= ST_SETTLE;
              osc_en     <= 1'b1;
              clkout_en  <= 1'b1;
              wdt_clk_en <= 1'b1;
              src_nmi_q  <= arb_nmi;
              src_idx_q  <= arb_idx;
              wake_cause <= arb_nmi ? CAUSE_NMI : (CAUSE_IRQ | 4'(arb_idx));
            end
          end
          ST_SETTLE: begin
            if (ovf) begin
              st          <= ST_RUN;
              sys_clk_en  <= 1'b1;
              wdt_clk_en  <= 1'b0;
              exc_nmi     <= src_nmi_q;
              exc_irq     <= !src_nmi_q;
              exc_irq_num <= src_idx_q;
            end
          end
          default: st <= ST_RUN;
        endcase
      end
    end
  end

  assign state = st;

  // R2: standby keeps every clock off
  a_r2_standby_dark: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STBY) |-> (!osc_en && !sys_clk_en && !wdt_clk_en && !clkout_en));

  // R5: settling feeds only the counter
  a_r5_settle_gating: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE) |-> (osc_en && wdt_clk_en && !sys_clk_en));

  // R7: wake exceptions only on leaving settling
  a_r7_exc_after_settle: assert property (@(posedge clk) disable iff (rst)
    (exc_nmi || exc_irq) |-> ($past(st) == ST_SETTLE && st == ST_RUN && sys_clk_en));

  // R8: without a qualified source, standby persists
  a_r8_no_hit_stays: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STBY && por_s && !arb_hit) |=> (st == ST_STBY));

  // R11: a low reset pin forces the run state with clocks on
  a_r11_por_force: assert property (@(posedge clk) disable iff (rst)
    (!por_s) |=> (st == ST_RUN && por_hold && sys_clk_en && !wdt_clk_en));

  // R12: at most one exception request at a time
  a_r12_one_exc: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_nmi, exc_irq, exc_reset}));
endmodule

// File: tb/stby_wake_seq_test.sv
module stby_wake_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_pin = 1'b0;
  logic [7:0]  irq_pin = '0;
  logic        por_n = 1'b1;
  logic        nmi_rise_sel = 1'b0;
  logic [15:0] irq_sense = '0;
  logic [31:0] irq_prio = '0;
  logic [3:0]  cpu_mask = '0;
  logic [2:0]  cks = '0;
  logic        stby_req = 1'b0;
  logic        osc_en, wdt_clk_en, sys_clk_en, clkout_en;
  logic        exc_nmi, exc_irq, exc_reset, por_hold;
  logic [2:0]  exc_irq_num;
  logic [1:0]  state;
  logic [3:0]  wake_cause;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int set_cnt = 0;

  typedef struct {int kind; int num; int len;} exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  stby_wake_seq uut (
    .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .irq_pin(irq_pin), .por_n(por_n),
    .nmi_rise_sel(nmi_rise_sel), .irq_sense(irq_sense), .irq_prio(irq_prio),
    .cpu_mask(cpu_mask), .cks(cks), .stby_req(stby_req),
    .osc_en(osc_en), .wdt_clk_en(wdt_clk_en), .sys_clk_en(sys_clk_en),
    .clkout_en(clkout_en), .exc_nmi(exc_nmi), .exc_irq(exc_irq),
    .exc_irq_num(exc_irq_num), .exc_reset(exc_reset), .por_hold(por_hold),
    .state(state), .wake_cause(wake_cause));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input int num, input int len);
    exp_t e;
    e.kind = kind; e.num = num; e.len = len;
    q.push_back(e);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enter_standby(input string tag);
    @(negedge clk);
    stby_req = 1'b1;
    @(negedge clk);
    stby_req = 1'b0;
    chk(state == 2'd1, tag, state, 1);
    chk({osc_en, sys_clk_en, wdt_clk_en, clkout_en} == 4'b0, tag,
        {osc_en, sys_clk_en, wdt_clk_en, clkout_en}, 0);
    chk(wake_cause == 4'd0, tag, wake_cause, 0);
  endtask

  task automatic wait_state(input logic [1:0] s, input int maxc, input string tag);
    int n = 0;
    while (state != s && n < maxc) begin
      @(negedge clk);
      n++;
    end
    chk(state == s, tag, state, s);
  endtask

  // monitor: compares exception pulses and settle length with the queue
  always @(negedge clk) begin
    if (!rst && (exc_nmi || exc_irq || exc_reset)) begin
      int kind;
      kind = exc_nmi ? 1 : (exc_irq ? 2 : 3);
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected exception: actual kind %0d expected none", kind);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (kind != e.kind || (kind == 2 && int'(exc_irq_num) != e.num)) begin
          errors++;
          $display("FAIL R7/R9 exception: actual kind %0d num %0d expected kind %0d num %0d",
                   kind, exc_irq_num, e.kind, e.num);
        end
        if (e.len >= 0) begin
          checks++;
          if (set_cnt != e.len) begin
            errors++;
            $display("FAIL R6 settle length: actual %0d expected %0d", set_cnt, e.len);
          end
        end
      end
    end
    set_cnt = (state == 2'd2) ? set_cnt + 1 : 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(4);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(state == 2'd0, "R1 state", state, 0);
    chk({sys_clk_en, osc_en, clkout_en, wdt_clk_en, por_hold} == 5'b11100, "R1 clocks",
        {sys_clk_en, osc_en, clkout_en, wdt_clk_en, por_hold}, 5'b11100);
    chk({exc_nmi, exc_irq, exc_reset} == 3'b0 && wake_cause == 4'd0, "R1 exc/cause",
        wake_cause, 0);

    // T1: NMI falling edge, cks 0 (R2 R3 R5 R6 R7 R10)
    nmi_pin = 1'b1; cycles(5);
    enter_standby("R2 entry");
    push(1, 0, 256);
    nmi_pin = 1'b0;
    wait_state(2'd2, 8, "R5 reach settling");
    chk({osc_en, clkout_en, wdt_clk_en, sys_clk_en} == 4'b1110, "R5 gating",
        {osc_en, clkout_en, wdt_clk_en, sys_clk_en}, 4'b1110);
    chk(wake_cause == 4'd1, "R10 NMI cause", wake_cause, 1);
    wait_state(2'd0, 300, "R7 back to run");
    chk(sys_clk_en && !wdt_clk_en, "R7 clocks", {sys_clk_en, wdt_clk_en}, 2'b10);
    chk(wake_cause == 4'd1, "R10 cause held", wake_cause, 1);

    // T2: rising select; falling edge ignored; cks captured at entry (R3 R6)
    nmi_rise_sel = 1'b1; nmi_pin = 1'b1; cycles(5);
    cks = 3'd1;
    enter_standby("R2 entry 2");
    cks = 3'd7;
    nmi_pin = 1'b0; cycles(8);
    chk(state == 2'd1, "R3 opposite edge ignored", state, 1);
    push(1, 0, 1024);
    nmi_pin = 1'b1;
    wait_state(2'd2, 8, "R3 rising wakes");
    wait_state(2'd0, 1100, "R6 settle cks1");

    // T3: IRQ sense fields and mask (R4 R8 R10)
    cks = 3'd0; cpu_mask = 4'd5;
    irq_sense = 16'b11_00_10_00_00_01_00_00;  // IRQ7 both, IRQ6 none, IRQ5 rise, IRQ2 fall
    irq_prio  = 32'h9F30_0700;                // IRQ7 9, IRQ6 15, IRQ5 3, IRQ2 7
    cycles(5);
    enter_standby("R2 entry 3");
    irq_pin[6] = 1'b1; cycles(8);
    chk(state == 2'd1, "R4 sense 00 ignored", state, 1);
    irq_pin[5] = 1'b1; cycles(8);
    chk(state == 2'd1, "R8 masked IRQ5", state, 1);
    chk(wake_cause == 4'd0, "R8 masked cause", wake_cause, 0);
    irq_pin[2] = 1'b1; cycles(8);
    chk(state == 2'd1, "R4 rise on fall-only ignored", state, 1);
    push(2, 2, 256);
    irq_pin[2] = 1'b0;
    wait_state(2'd2, 8, "R4 falling wakes IRQ2");
    chk(wake_cause == 4'd10, "R10 IRQ2 cause", wake_cause, 10);
    wait_state(2'd0, 300, "R7 IRQ2 exit");

    // T4: IRQ2 and IRQ7 together, lowest index wins (R9)
    irq_pin[2] = 1'b1; cycles(5);
    enter_standby("R2 entry 4");
    push(2, 2, 256);
    irq_pin[2] = 1'b0; irq_pin[7] = 1'b1;
    wait_state(2'd2, 8, "R9 settling");
    chk(wake_cause == 4'd10, "R9 lowest IRQ wins", wake_cause, 10);
    wait_state(2'd0, 300, "R9 exit");

    // T5: NMI and IRQ7 falling together, NMI wins (R9 R4 both-edge)
    nmi_rise_sel = 1'b0; cycles(5);
    enter_standby("R2 entry 5");
    push(1, 0, 256);
    nmi_pin = 1'b0; irq_pin[7] = 1'b0;
    wait_state(2'd2, 8, "R9 NMI settling");
    chk(wake_cause == 4'd1, "R9 NMI over IRQ", wake_cause, 1);
    wait_state(2'd0, 300, "R9 NMI exit");

    // T6: priority equal to mask accepted, both-edge rising (R8 R4)
    cpu_mask = 4'd9; cycles(5);
    enter_standby("R2 entry 6");
    push(2, 7, 256);
    irq_pin[7] = 1'b1;
    wait_state(2'd2, 8, "R8 prio equal mask");
    chk(wake_cause == 4'd15, "R10 IRQ7 cause", wake_cause, 15);
    wait_state(2'd0, 300, "R8 exit");

    // T7: reset during settling, stby_req ignored while held (R11 R12)
    cks = 3'd2; cycles(5);
    enter_standby("R2 entry 7");
    irq_pin[7] = 1'b0;
    wait_state(2'd2, 8, "R11 settling");
    cycles(100);
    por_n = 1'b0; cycles(4);
    chk(state == 2'd0 && por_hold, "R11 reset in settling", {state, por_hold}, 1);
    chk({sys_clk_en, osc_en, clkout_en, wdt_clk_en} == 4'b1110, "R11 clocks",
        {sys_clk_en, osc_en, clkout_en, wdt_clk_en}, 4'b1110);
    chk(wake_cause == 4'd2, "R11 reset cause", wake_cause, 2);
    stby_req = 1'b1; @(negedge clk); stby_req = 1'b0; cycles(2);
    chk(state == 2'd0 && sys_clk_en, "R11 stby_req ignored", state, 0);
    push(3, 0, -1);
    por_n = 1'b1; cycles(6);
    chk(!por_hold, "R12 hold cleared", por_hold, 0);

    // T8: edges in RUN ignored (R13)
    nmi_pin = 1'b1; irq_pin = 8'hFF; cycles(6);
    nmi_pin = 1'b0; irq_pin = 8'h00; cycles(6);
    chk(state == 2'd0 && wake_cause == 4'd2, "R13 run edges ignored", wake_cause, 2);

    // T9: reset during standby (R11 R12)
    cks = 3'd0;
    enter_standby("R2 entry 9");
    por_n = 1'b0; cycles(4);
    chk(state == 2'd0 && wake_cause == 4'd2, "R11 reset in standby", wake_cause, 2);
    push(3, 0, -1);
    por_n = 1'b1; cycles(6);

    chk(q.size() == 0, "R7 all expected exceptions seen", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule